// File: doc/BRIEF.md
# DMA Transfer Byte Counter with Reload

This block keeps the working byte count for a DMA-style transfer engine. Software programs a start count one byte at a time into a set of shadow registers. Those writes never disturb the count that is currently running. When a command arrives with its DMA bit set, the working count is loaded from the shadow value. A shadow value of zero is treated as the largest window, 65536 bytes. After that, every byte that passes through the programmed-I/O data port lowers the working count by one.

The data port takes either one byte or two bytes per access. On a two-byte access the upper byte is moved first and the lower byte second, and each byte is counted on its own. The port stops moving bytes once the count is exhausted. A terminal-count flag reports that the count has run out. A one-cycle completion pulse fires when an armed completion request sees a port access leave the count at zero. The armed state is then dropped. The upper readback byte shows a fixed identification value until software first writes the upper shadow byte.

The completion logic is a three-state machine. In IDLE nothing is armed, and `cmp_arm` moves it to ARMED. In ARMED, a port access whose resulting count is zero moves it to FIRE. FIRE lasts one cycle and drives `done_pulse`. From FIRE the machine returns to IDLE, or goes back to ARMED if `cmp_arm` is asserted in that cycle.

Top module: `xfer_counter`

## Requirements
- R1: After reset the working count is 0, `tc_flag` is 0, `done_pulse` is 0, and `cnt_hi` reads CHIP_ID (default 8'hC3).
- R2: A host write (`reg_wr`) with `reg_sel` 0, 1 or 2 stores `reg_wdata` into the low, middle or high shadow byte, and the working count readback is unchanged the next cycle.
- R3: Any host write to a count byte clears `tc_flag` on the next cycle.
- R4: `cmd_wr` with `cmd_dma`=1 loads the working count with low | mid<<8 | high<<16 of the shadow bytes. `cmd_wr` with `cmd_dma`=0 leaves the count unchanged.
- R5: A reload from a shadow value of zero loads 0x010000 (65536).
- R6: A one-byte access (`pd_go`=1, `pd_wide`=0) moves one byte on lane bit 0 of `lane_moved` and lowers the count by 1. At count zero, `lane_moved` is 00 and the count stays 0.
- R7: A two-byte access (`pd_wide`=1) moves the upper lane (bit 1) first and the lower lane (bit 0) second. With count 1 only bit 1 is set and the count becomes 0. With count 2 or more both bits are set and the count drops by 2.
- R8: `tc_flag` rises the cycle after an access that moves at least one byte and leaves the count at zero.
- R9: When armed (ARMED state), an access whose resulting count is zero gives `done_pulse`=1 for exactly one cycle, on the cycle after the access. The request is then disarmed, so a further access at zero gives no pulse.
- R10: `cnt_hi` returns CHIP_ID until the first host write with `reg_sel`=2. After that it returns bits 23:16 of the working count.
- R11: When a reload and a port access happen in the same cycle, the reload wins and `lane_moved` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe to a count byte |
| reg_sel | input | 2 | Byte select: 0 low, 1 mid, 2 high |
| reg_wdata | input | 8 | Host write data |
| cmd_wr | input | 1 | Command write strobe |
| cmd_dma | input | 1 | DMA bit of the written command |
| cmp_arm | input | 1 | Arms the completion request |
| pd_go | input | 1 | Data-port access strobe (read or write) |
| pd_wide | input | 1 | Access is two bytes wide |
| cnt_lo | output | 8 | Working count bits 7:0 |
| cnt_mid | output | 8 | Working count bits 15:8 |
| cnt_hi | output | 8 | Working count bits 23:16, or CHIP_ID before first high write |
| lane_moved | output | 2 | Bytes moved this access: bit 1 upper, bit 0 lower/single |
| tc_flag | output | 1 | Terminal count reached |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: a 24-bit count, a zero-start reload of 65536 and CHIP_ID 8'hC3. A 24-bit width lets the bench show the zero-start reload landing exactly in the high byte as 0x01, and a three-byte reload that touches every byte. Small counts of 1, 2 and 3 bring the partial two-byte access, the stop at zero and the completion pulse within a few cycles of each other.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } cmpl_state_t;
endpackage

// File: rtl/xfc_start_regs.sv
module xfc_start_regs #(
    parameter int NBYTES  = 3,
    parameter int SEL_W   = 2,
    parameter int CHIP_ID = 8'hC3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic [7:0]            reg_wdata,
    output logic [NBYTES*8-1:0]   start_cnt,
    output logic                  hi_written
);
    localparam int HI_IDX = NBYTES - 1;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [7:0] shadow_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= 8'h00;
            end else if (reg_wr && (reg_sel == SEL_W'(b))) begin
                shadow_q <= reg_wdata;
            end
        end
        assign start_cnt[b*8 +: 8] = shadow_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_written <= 1'b0;
        end else if (reg_wr && (reg_sel == SEL_W'(HI_IDX))) begin
            hi_written <= 1'b1;
        end
    end

    // R10: once the upper byte has been written the flag never drops
    a_r10_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hi_written |=> hi_written);
endmodule

// File: rtl/xfc_count_core.sv
module xfc_count_core #(
    parameter int CNT_W     = 24,
    parameter int ZERO_LOAD = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             acc_en,
    input  logic             acc_wide,
    input  logic             reg_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [1:0]       lanes,
    output logic             tc_q,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ZL  = CNT_W'(ZERO_LOAD);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] moved;
    logic             acc_live;

    assign acc_live = acc_en && !load_en;

    always_comb begin
        lanes = 2'b00;
        if (acc_live) begin
            if (acc_wide) begin
                lanes[1] = (cnt_q != '0);
                lanes[0] = (cnt_q > ONE);
            end else begin
                lanes[0] = (cnt_q != '0);
            end
        end
    end

    assign moved = CNT_W'(lanes[1]) + CNT_W'(lanes[0]);

    always_comb begin
        if (load_en) begin
            cnt_d = (start_cnt == '0) ? ZL : start_cnt;
        end else begin
            cnt_d = cnt_q - moved;
        end
    end

    assign hit_zero = acc_live && (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (reg_wr || load_en) begin
            tc_q <= 1'b0;
        end else if ((lanes != 2'b00) && (cnt_d == '0)) begin
            tc_q <= 1'b1;
        end
    end

    // R4 / R5: reload value follows the shadow count, zero maps to the large window
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cnt_q == (($past(start_cnt) == '0) ? ZL : $past(start_cnt)));
    // R6: a live access on a non-zero count always lowers it
    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_live && cnt_q != '0) |=> cnt_q < $past(cnt_q));
    // R6: no wrap below zero
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_live && cnt_q == '0) |=> cnt_q == '0);
    // R3: a count-byte write clears terminal count
    a_r3_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !tc_q);
endmodule

// File: rtl/xfc_done_fsm.sv
module xfc_done_fsm
    import xfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_arm,
    input  logic hit_zero,
    output logic done_pulse
);
    cmpl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmp_arm)  state_d = ST_ARMED;
            ST_ARMED: if (hit_zero) state_d = ST_FIRE;
            ST_FIRE:  state_d = cmp_arm ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done_pulse = (state_q == ST_FIRE);
    end

    // R9: the completion pulse lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R9: only an armed request can fire
    a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !done_pulse);
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W     = 24,
    parameter int ZERO_LOAD = 65536,
    parameter int CHIP_ID   = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       cmd_wr,
    input  logic       cmd_dma,
    input  logic       cmp_arm,
    input  logic       pd_go,
    input  logic       pd_wide,
    output logic [7:0] cnt_lo,
    output logic [7:0] cnt_mid,
    output logic [7:0] cnt_hi,
    output logic [1:0] lane_moved,
    output logic       tc_flag,
    output logic       done_pulse
);
    localparam int NBYTES = CNT_W / 8;

    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic             hi_written;
    logic             load_en;
    logic             hit_zero;

    assign load_en = cmd_wr && cmd_dma;

    xfc_start_regs #(
        .NBYTES (NBYTES),
        .SEL_W  (2),
        .CHIP_ID(CHIP_ID)
    ) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .start_cnt (start_cnt),
        .hi_written(hi_written)
    );

    xfc_count_core #(
        .CNT_W    (CNT_W),
        .ZERO_LOAD(ZERO_LOAD)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .start_cnt(start_cnt),
        .acc_en   (pd_go),
        .acc_wide (pd_wide),
        .reg_wr   (reg_wr),
        .cnt_q    (cnt_q),
        .lanes    (lane_moved),
        .tc_q     (tc_flag),
        .hit_zero (hit_zero)
    );

    xfc_done_fsm u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_arm   (cmp_arm),
        .hit_zero  (hit_zero),
        .done_pulse(done_pulse)
    );

    assign cnt_lo  = cnt_q[7:0];
    assign cnt_mid = cnt_q[15:8];
    assign cnt_hi  = hi_written ? cnt_q[CNT_W-1:CNT_W-8] : 8'(CHIP_ID);

    // R2: a shadow write alone never moves the working count
    a_r2_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !load_en && !pd_go) |=> $stable(cnt_q));
    // R11: reload beats a concurrent access
    a_r11_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && pd_go) |-> lane_moved == 2'b00);
endmodule

// File: tb/xfer_counter_tb_top.sv
`timescale 1ns/1ps
module xfer_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       cmd_wr = 1'b0;
    logic       cmd_dma = 1'b0;
    logic       cmp_arm = 1'b0;
    logic       pd_go = 1'b0;
    logic       pd_wide = 1'b0;
    logic [7:0] cnt_lo, cnt_mid, cnt_hi;
    logic [1:0] lane_moved;
    logic       tc_flag, done_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [7:0] ID = 8'hC3;

    always #4 clk = ~clk;

    xfer_counter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_wr(cmd_wr), .cmd_dma(cmd_dma),
        .cmp_arm(cmp_arm), .pd_go(pd_go), .pd_wide(pd_wide),
        .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .cnt_hi(cnt_hi),
        .lane_moved(lane_moved), .tc_flag(tc_flag), .done_pulse(done_pulse)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int count_now();
        return {cnt_hi, cnt_mid, cnt_lo};
    endfunction

    task automatic host_wr(input logic [1:0] sel, input logic [7:0] val);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input logic dma);
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_dma = dma;
        @(posedge clk); #1;
        cmd_wr = 1'b0; cmd_dma = 1'b0;
    endtask

    task automatic access(input logic wide, input logic [1:0] exp_lanes, input string tag);
        @(posedge clk); #1;
        pd_go = 1'b1; pd_wide = wide;
        #1;
        chk(tag, lane_moved, exp_lanes);
        @(posedge clk); #1;
        pd_go = 1'b0; pd_wide = 1'b0;
    endtask

    task automatic arm();
        @(posedge clk); #1;
        cmp_arm = 1'b1;
        @(posedge clk); #1;
        cmp_arm = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 lo", cnt_lo, 0);
        chk("R1 mid", cnt_mid, 0);
        chk("R1 hi id", cnt_hi, ID);
        chk("R1 tc", tc_flag, 0);
        chk("R1 done", done_pulse, 0);
    endtask

    task automatic t_shadow_and_reload();
        host_wr(2'd0, 8'h03);
        chk("R2 lo unchanged", cnt_lo, 0);
        host_wr(2'd1, 8'h00);
        chk("R2 mid unchanged", cnt_mid, 0);
        chk("R10 hi still id", cnt_hi, ID);
        cmd(1'b0);
        chk("R4 no-dma cmd ignored", cnt_lo, 0);
        cmd(1'b1);
        chk("R4 reload lo", cnt_lo, 3);
    endtask

    task automatic t_count_down();
        access(1'b0, 2'b01, "R6 single lane");
        chk("R6 count 2", cnt_lo, 2);
        arm();
        access(1'b1, 2'b11, "R7 wide both lanes");
        chk("R7 count 0", cnt_lo, 0);
        chk("R8 tc set", tc_flag, 1);
        chk("R9 done pulse", done_pulse, 1);
        @(posedge clk); #1;
        chk("R9 pulse one cycle", done_pulse, 0);
        access(1'b0, 2'b00, "R6 nothing at zero");
        chk("R6 stays zero", cnt_lo, 0);
        chk("R9 disarmed no pulse", done_pulse, 0);
    endtask

    task automatic t_hi_and_tc();
        host_wr(2'd2, 8'h00);
        chk("R3 tc cleared", tc_flag, 0);
        chk("R10 hi shows count", cnt_hi, 0);
    endtask

    task automatic t_zero_start();
        host_wr(2'd0, 8'h00);
        cmd(1'b1);
        chk("R5 zero start loads 65536", count_now(), 32'h010000);
    endtask

    task automatic t_wide_partial();
        host_wr(2'd0, 8'h01);
        cmd(1'b1);
        chk("R4 count 1", count_now(), 1);
        access(1'b1, 2'b10, "R7 upper lane only");
        chk("R7 partial to zero", count_now(), 0);
    endtask

    task automatic t_full_reload();
        host_wr(2'd0, 8'h05);
        host_wr(2'd1, 8'h01);
        host_wr(2'd2, 8'h02);
        cmd(1'b1);
        chk("R4 three-byte reload", count_now(), 32'h020105);
        access(1'b1, 2'b11, "R7 wide mid count");
        chk("R7 minus two", count_now(), 32'h020103);
    endtask

    task automatic t_collision();
        host_wr(2'd0, 8'h09);
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_dma = 1'b1; pd_go = 1'b1; pd_wide = 1'b1;
        #1;
        chk("R11 no lanes on reload", lane_moved, 0);
        @(posedge clk); #1;
        cmd_wr = 1'b0; cmd_dma = 1'b0; pd_go = 1'b0; pd_wide = 1'b0;
        chk("R11 reload value kept", count_now(), 32'h020109);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_shadow_and_reload();
        t_count_down();
        t_hi_and_tc();
        t_zero_start();
        t_wide_partial();
        t_full_reload();
        t_collision();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule